// File: doc/BRIEF.md
# Sphere Decoder Child Enumerator

This block picks the children of one level of a real-valued, depth-first sphere-decoder tree. The caller presents the interference-cancelled value `psi` and the diagonal gain `rll` of that level, both signed 16-bit fixed point with 9 fractional bits, and strobes `load`. One cycle later the block shows the PAM symbol that lies nearest to the real estimate `psi/rll`. It gets there without a general divider. A restoring shift-and-subtract division runs for only as many steps as the chosen PAM order needs, so its quotient saturates at the top of the constellation by itself. That truncated quotient is then rounded to the nearest odd point.

Each later `next` strobe, after a prune, gives the next child in order of growing distance from the estimate. The order is a zigzag. It starts at the nearest point and moves to the closest point on the other side of the estimate, then alternates outward. A point beyond the edge of the constellation is skipped without a gap cycle, and the walk goes on along the side that still has points left. When both sides are used up, the block raises `exhausted`. The PAM order is chosen per load with `pam_sel`, so one circuit serves 4-, 16- and 64-QAM trees.

Top module: `sd_child_enum`

## Requirements
- R1: While `rst` is high and after it, until the first `load`, `sym` is 0 and both `sym_valid` and `exhausted` are low.
- R2: The cycle after `load`, `sym` holds the odd integer nearest to `psi/rll`, clamped to ±(Q−1), with `sym_valid` high and `exhausted` low. `sym` is 4-bit two's complement.
- R3: A negative `rll` gives the correct sign of the ratio: the first symbol for (psi, rll) equals the one for (−psi, −rll).
- R4: The second symbol is the nearest odd point on the other side of the estimate from the first. When the estimate falls exactly on an odd point, the second symbol is the one a step of 2 away from zero.
- R5: Later symbols alternate between the two sides of the first symbol, each one 2 further out than the previous on its side. A point outside ±(Q−1) is skipped in the same cycle and the remaining side continues.
- R6: Each `next` while `sym_valid` is high gives the next symbol one cycle later. A load yields each of the Q points exactly once.
- R7: A `next` when no point is left drops `sym_valid`, raises `exhausted` and keeps `sym`. Further `next` strobes change nothing.
- R8: `pam_sel` encodes 00 = 2-PAM, 01 = 4-PAM, 10 and 11 = 8-PAM. It is sampled only on `load`, and later changes do not affect the walk in progress.
- R9: `load` has priority over `next` in the same cycle and restarts the walk from the new operands.
- R10: A `next` while `sym_valid` is low and no `load` is present has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a new level from `psi`, `rll`, `pam_sel` |
| next | input | 1 | Advance to the next child |
| pam_sel | input | 2 | PAM order select (see R8) |
| psi | input | DATA_W | Interference-cancelled value, signed Q7.9 |
| rll | input | DATA_W | Diagonal gain, signed Q7.9, nonzero |
| sym | output | 4 | Current child symbol, two's complement odd integer |
| sym_valid | output | 1 | `sym` is a live child |
| exhausted | output | 1 | All children of this level have been given |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. The first symbol follows `load` by one edge, each further symbol follows `next` by one edge, and the `exhausted` flag follows the `next` that finds no point left. The bench changes inputs on the falling edge, lets one rising edge pass and then samples on the following falling edge, so each check reads the register written by that one strobe. A table of operand sets is walked to exhaustion: rounding on both sides of zero, negative gain, saturation, an exact hit and every PAM order. Directed cases follow for reset, ignored strobes, load priority and a change of `pam_sel` in the middle of a walk.

// File: rtl/sd_enum_pkg.sv
package sd_enum_pkg;

    // Three selectable orders (2/4/8-PAM) -> at most three quotient bits.
    localparam int SD_MAX_LOG = 3;
    // Symbol width holds +/-(2^SD_MAX_LOG - 1).
    localparam int SD_SYM_W   = SD_MAX_LOG + 1;
    // Walk pointers may step one point past the edge.
    localparam int SD_PTR_W   = SD_SYM_W + 2;
    localparam int SD_LVL_W   = $clog2(SD_MAX_LOG + 1);

    typedef enum logic [1:0] {
        PAM_2    = 2'd0,
        PAM_4    = 2'd1,
        PAM_8    = 2'd2,
        PAM_8ALT = 2'd3
    } pam_mode_e;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    typedef struct packed {
        logic                        up;
        logic signed [SD_PTR_W-1:0]  first;
    } seed_t;

    function automatic logic [SD_LVL_W-1:0] mode_levels(input pam_mode_e m);
        case (m)
            PAM_2:   return SD_LVL_W'(1);
            PAM_4:   return SD_LVL_W'(2);
            default: return SD_LVL_W'(3);
        endcase
    endfunction

    function automatic logic signed [SD_PTR_W-1:0] edge_of(input logic [SD_LVL_W-1:0] lvl);
        return SD_PTR_W'((1 << lvl) - 1);
    endfunction

endpackage

// File: rtl/sd_operand_prep.sv
module sd_operand_prep #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] psi,
    input  logic signed [DATA_W-1:0] rll,
    output logic        [DATA_W:0]   num_mag,
    output logic        [DATA_W:0]   den_mag,
    output logic                     neg
);
    logic signed [DATA_W:0] psi_e, rll_e, num_s, den_s;

    always_comb begin
        psi_e = {psi[DATA_W-1], psi};
        rll_e = {rll[DATA_W-1], rll};
        // Flip both operands for a negative gain so the divisor is positive.
        if (rll_e < 0) begin
            num_s = -psi_e;
            den_s = -rll_e;
        end else begin
            num_s = psi_e;
            den_s = rll_e;
        end
        neg     = num_s < 0;
        num_mag = neg ? DATA_W'(0) - num_s : num_s;
        den_mag = den_s;
    end
endmodule

// File: rtl/sd_trunc_divider.sv
module sd_trunc_divider
    import sd_enum_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W:0]        num_mag,
    input  logic [DATA_W:0]        den_mag,
    input  logic [SD_LVL_W-1:0]    lvl,
    output logic [SD_MAX_LOG-1:0]  quo
);
    localparam int REM_W = DATA_W + 1 + SD_MAX_LOG;

    always_comb begin
        logic [REM_W-1:0] rem;
        logic [REM_W-1:0] trial;
        int pos;
        rem   = REM_W'(num_mag);
        trial = '0;
        pos   = 0;
        quo   = '0;
        // Only the first lvl restoring steps run; an oversized numerator
        // leaves every bit set, which saturates at Q-1.
        for (int j = 0; j < SD_MAX_LOG; j++) begin
            if (j < int'(lvl)) begin
                pos   = int'(lvl) - 1 - j;
                trial = REM_W'(den_mag) << pos;
                if (rem >= trial) begin
                    rem = rem - trial;
                    quo = quo | (SD_MAX_LOG'(1) << pos);
                end
            end
        end
    end
endmodule

// File: rtl/sd_seed_round.sv
module sd_seed_round
    import sd_enum_pkg::*;
(
    input  logic [SD_MAX_LOG-1:0] quo,
    input  logic                  neg,
    output seed_t                 seed
);
    logic signed [SD_PTR_W-1:0] mag;

    always_comb begin
        // floor(|x|) -> nearest odd point: 2m and 2m+1 both round to 2m+1.
        mag        = SD_PTR_W'({quo[SD_MAX_LOG-1:1], 1'b1});
        seed.first = neg ? -mag : mag;
        // Even floor: estimate sits below the odd point in magnitude.
        seed.up    = quo[0] ^ neg;
    end
endmodule

// File: rtl/sd_zigzag_walker.sv
module sd_zigzag_walker
    import sd_enum_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic                        next,
    input  seed_t                       seed,
    input  logic signed [SD_PTR_W-1:0]  lim_in,
    output logic        [SD_SYM_W-1:0]  sym,
    output logic                        sym_valid,
    output logic                        exhausted
);
    logic signed [SD_PTR_W-1:0] ptr_a, ptr_b, lim_q, step_a, seed_step;
    logic                       dir_a;
    side_e                      turn;
    logic                       a_ok, b_ok, take_a, take_b;

    function automatic logic inside_lim(input logic signed [SD_PTR_W-1:0] p,
                                        input logic signed [SD_PTR_W-1:0] l);
        return (p <= l) && (p >= -l);
    endfunction

    always_comb begin
        step_a    = dir_a ? SD_PTR_W'(2) : -SD_PTR_W'(2);
        seed_step = seed.up ? SD_PTR_W'(2) : -SD_PTR_W'(2);
        a_ok      = inside_lim(ptr_a, lim_q);
        b_ok      = inside_lim(ptr_b, lim_q);
        take_a    = a_ok && ((turn == SIDE_A) || !b_ok);
        take_b    = b_ok && !take_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym       <= '0;
            sym_valid <= 1'b0;
            exhausted <= 1'b0;
            ptr_a     <= '0;
            ptr_b     <= '0;
            lim_q     <= '0;
            dir_a     <= 1'b0;
            turn      <= SIDE_A;
        end else if (load) begin
            sym       <= seed.first[SD_SYM_W-1:0];
            ptr_a     <= seed.first + seed_step;
            ptr_b     <= seed.first - seed_step;
            dir_a     <= seed.up;
            lim_q     <= lim_in;
            turn      <= SIDE_A;
            sym_valid <= 1'b1;
            exhausted <= 1'b0;
        end else if (next && sym_valid) begin
            if (take_a) begin
                sym   <= ptr_a[SD_SYM_W-1:0];
                ptr_a <= ptr_a + step_a;
                turn  <= SIDE_B;
            end else if (take_b) begin
                sym   <= ptr_b[SD_SYM_W-1:0];
                ptr_b <= ptr_b - step_a;
                turn  <= SIDE_A;
            end else begin
                sym_valid <= 1'b0;
                exhausted <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sd_child_enum.sv
module sd_child_enum
    import sd_enum_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     next,
    input  logic [1:0]               pam_sel,
    input  logic signed [DATA_W-1:0] psi,
    input  logic signed [DATA_W-1:0] rll,
    output logic [SD_SYM_W-1:0]      sym,
    output logic                     sym_valid,
    output logic                     exhausted
);
    logic [DATA_W:0]              num_mag, den_mag;
    logic                         neg;
    logic [SD_LVL_W-1:0]          lvl;
    logic [SD_MAX_LOG-1:0]        quo;
    seed_t                        seed;
    logic signed [SD_PTR_W-1:0]   lim;

    assign lvl = mode_levels(pam_mode_e'(pam_sel));
    assign lim = edge_of(lvl);

    sd_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .psi     (psi),
        .rll     (rll),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .neg     (neg)
    );

    sd_trunc_divider #(.DATA_W(DATA_W)) u_div (
        .num_mag (num_mag),
        .den_mag (den_mag),
        .lvl     (lvl),
        .quo     (quo)
    );

    sd_seed_round u_seed (
        .quo  (quo),
        .neg  (neg),
        .seed (seed)
    );

    sd_zigzag_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .next      (next),
        .seed      (seed),
        .lim_in    (lim),
        .sym       (sym),
        .sym_valid (sym_valid),
        .exhausted (exhausted)
    );
endmodule

// File: rtl/sd_enum_checker.sv
module sd_enum_checker (
    input logic       clk,
    input logic       rst,
    input logic       load,
    input logic       next,
    input logic [1:0] pam_sel,
    input logic [3:0] sym,
    input logic       sym_valid,
    input logic       exhausted
);
    logic [3:0] edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= 4'd7;
        end else if (load) begin
            case (pam_sel)
                2'd0:    edge_q <= 4'd1;
                2'd1:    edge_q <= 4'd3;
                default: edge_q <= 4'd7;
            endcase
        end
    end

    AST_SYM_ODD: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> sym[0]); // R2

    AST_SYM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (int'($signed(sym)) <= int'(edge_q)) && (int'($signed(sym)) >= -int'(edge_q))); // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && exhausted)); // R7

    AST_LOAD_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        load |=> sym_valid && !exhausted); // R9

    AST_EXHAUST_STICKY: assert property (@(posedge clk) disable iff (rst)
        exhausted && !load |=> exhausted && $stable(sym)); // R7

    AST_NEXT_MOVES: assert property (@(posedge clk) disable iff (rst)
        sym_valid && next && !load |=> (sym != $past(sym)) || exhausted); // R6

    AST_IDLE_NEXT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !sym_valid && !load |=> !sym_valid && $stable(sym)); // R10
endmodule

bind sd_child_enum sd_enum_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .next      (next),
    .pam_sel   (pam_sel),
    .sym       (sym),
    .sym_valid (sym_valid),
    .exhausted (exhausted)
);

// File: tb/tb_sd_child_enum.sv
module tb_sd_child_enum;
    logic              clk = 1'b0;
    logic              rst, load, next;
    logic [1:0]        pam_sel;
    logic signed [15:0] psi, rll;
    logic [3:0]        sym;
    logic              sym_valid, exhausted;
    int                n_chk = 0;
    int                n_bad = 0;

    always #5 clk = ~clk;

    sd_child_enum dut (
        .clk(clk), .rst(rst), .load(load), .next(next), .pam_sel(pam_sel),
        .psi(psi), .rll(rll), .sym(sym), .sym_valid(sym_valid), .exhausted(exhausted)
    );

    // Symbols as 4-bit nibbles, first symbol in the top nibble.
    localparam int NV = 11;
    localparam logic [1:0]         V_PAM [NV] = '{2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd3, 2'd1};
    localparam logic signed [15:0] V_PSI [NV] = '{16'sd1331, -16'sd1331, 16'sd666, 16'sd5120, 16'sd205, -16'sd1536,
                                                 16'sd1536, -16'sd51, 16'sd3174, -16'sd922, 16'sd1331};
    localparam logic signed [15:0] V_RLL [NV] = '{16'sd512, 16'sd512, -16'sd256, 16'sd512, 16'sd1024, 16'sd384,
                                                 16'sd512, 16'sd154, 16'sd512, -16'sd256, 16'sd512};
    localparam int                 V_CNT [NV] = '{8, 8, 4, 4, 2, 2, 8, 8, 8, 8, 4};
    localparam logic [31:0]        V_SEQ [NV] = '{32'h315F7DB9, 32'hDFB19357, 32'hDF130000, 32'h31FD0000,
                                                 32'h1F000000, 32'hF1000000, 32'h3517FDB9, 32'hF1D3B597,
                                                 32'h7531FDB9, 32'h3517FDB9, 32'h31FD0000};

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] p, input logic signed [15:0] a, input logic signed [15:0] b);
        @(negedge clk);
        pam_sel = p; psi = a; rll = b; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_next();
        @(negedge clk);
        next = 1'b1;
        @(negedge clk);
        next = 1'b0;
    endtask

    function automatic int nib(input logic [31:0] s, input int k);
        return int'($signed(s[31-4*k -: 4]));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; load = 1'b0; next = 1'b0; pam_sel = 2'd0; psi = '0; rll = 16'sd512;
        repeat (3) @(negedge clk);
        chk("R1 sym in reset", int'(sym), 0);
        chk("R1 valid in reset", int'(sym_valid), 0);
        chk("R1 exhausted in reset", int'(exhausted), 0);
        rst = 1'b0;

        // R10: next with nothing loaded does nothing
        do_next();
        chk("R10 valid after idle next", int'(sym_valid), 0);
        chk("R10 exhausted after idle next", int'(exhausted), 0);
        chk("R1 sym after idle next", int'(sym), 0);

        for (int v = 0; v < NV; v++) begin
            do_load(V_PAM[v], V_PSI[v], V_RLL[v]);
            chk($sformatf("R2/R3 first symbol vec %0d", v), int'($signed(sym)), nib(V_SEQ[v], 0));
            chk($sformatf("R2 valid vec %0d", v), int'(sym_valid), 1);
            chk($sformatf("R2 exhausted low vec %0d", v), int'(exhausted), 0);
            for (int k = 1; k < V_CNT[v]; k++) begin
                do_next();
                chk($sformatf("%s/R6/R8 vec %0d step %0d", (k == 1) ? "R4" : "R5", v, k),
                    int'($signed(sym)), nib(V_SEQ[v], k));
                chk($sformatf("R6 valid vec %0d step %0d", v, k), int'(sym_valid), 1);
            end
            do_next();
            chk($sformatf("R7 exhausted vec %0d", v), int'(exhausted), 1);
            chk($sformatf("R7 valid low vec %0d", v), int'(sym_valid), 0);
            chk($sformatf("R7 sym held vec %0d", v), int'($signed(sym)), nib(V_SEQ[v], V_CNT[v] - 1));
        end

        // R7: further next after exhaustion changes nothing
        do_next();
        chk("R7 sticky exhausted", int'(exhausted), 1);
        chk("R7 sticky valid", int'(sym_valid), 0);
        chk("R7 sticky sym", int'($signed(sym)), -3);

        // R9: load and next together, load wins
        do_load(2'd2, 16'sd1331, 16'sd512);
        do_next();
        chk("R9 pre walk sym", int'($signed(sym)), 1);
        @(negedge clk);
        pam_sel = 2'd2; psi = -16'sd1331; rll = 16'sd512; load = 1'b1; next = 1'b1;
        @(negedge clk);
        load = 1'b0; next = 1'b0;
        chk("R9 load over next sym", int'($signed(sym)), -3);
        chk("R9 load over next valid", int'(sym_valid), 1);

        // R8: pam_sel change mid walk is not seen
        do_load(2'd2, -16'sd51, 16'sd154);
        pam_sel = 2'd0;
        do_next();
        chk("R8 mid-walk step 1", int'($signed(sym)), 1);
        do_next();
        chk("R8 mid-walk step 2 beyond 2-PAM", int'($signed(sym)), -3);
        chk("R8 mid-walk valid", int'(sym_valid), 1);

        // R1: reset in the middle of a walk
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid walk sym", int'(sym), 0);
        chk("R1 reset mid walk valid", int'(sym_valid), 0);
        chk("R1 reset mid walk exhausted", int'(exhausted), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule